// File: doc/BRIEF.md
# Disk Attachment Status Interrupt Engine

This block services the interrupt of a disk attachment in hardware, so the host never polls the status port. The engine waits for the attachment's interrupt flag. It reads the interrupt status byte once, and that read clears the interrupt at the attachment. From the byte it takes the device number and the interrupt ID. If the status interface is holding a word at that moment, the engine collects a status block. The first word of the block states the block length and the command code. The engine pops each further word only when the attachment reports the interface full again.

After the fetch the engine dispatches on the interrupt ID. It updates a result code, latches the residual block count for data transfers and raises a completion pulse. Where the ID needs it, the engine writes an end-of-interrupt attention byte to the attachment's sequencer port. For the data-transfer-ready ID it writes the control register instead, so that the DMA transfer starts. DMA movement, command submission and the decoding of error codes lie outside this block.

Top module: `stsirq_engine`

## Requirements
- R1: After reset, `result` is 2'b00 (idle), `fatal`, `resid` and `stat_blk` are zero, and no read strobe is raised while `irq_flag` is low.
- R2: When idle with `irq_flag` high, exactly one `isr_rd` pulse is raised. The device number is taken from `isr_data[7:5]` and the interrupt ID from `isr_data[3:0]`. Bit 4 is ignored.
- R3: Interrupt IDs 0, 2 and 4 are spurious. For them no status word is popped, no attention, control write or `wake` is raised, and the result is unchanged.
- R4: If `sifr_full` is high in the cycle after the status byte is read, word 0 is popped. The block length is word 0 bits 15:8, and a length of 0 counts as 1. Each further word is popped only in a cycle where `sifr_full` is high. Exactly the stated number of words is popped. Only the first 8 are stored, as word i at `stat_blk[16*i +: 16]`, and unfilled slots read zero.
- R5: If `sifr_full` is low in that cycle, nothing is popped, `stat_blk` keeps its previous content, and the interrupt carries no command.
- R6: ID 0xB (data transfer ready) writes 8'h03 to the control port (bit 0 interrupt enable, bit 1 DMA enable). It raises no attention and no `wake`, and leaves the result unchanged.
- R7: IDs 1, 3, 5 and 8 set `result` to 2'b01 (done). IDs 9 and 0xA leave it unchanged. Every other non-spurious ID except 0xB sets it to 2'b10 (error).
- R8: The engine writes the attention byte {device number, 5'h02} for every non-spurious ID except 0xB and 0xF.
- R9: A one-cycle `wake` pulse is raised for every non-spurious ID except 0xB.
- R10: When word 0 bits 4:0 of a block fetched for this interrupt equal 1 (read) or 2 (write), and the ID is not 0xB, `resid` takes stored word 3.
- R11: ID 0xF (attention error) sets `fatal`, which stays set until reset.
- R12: The engine accepts a new interrupt in the cycle right after a dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_flag | input | 1 | Interrupt bit of the attachment's status register |
| isr_data | input | 8 | Interrupt status byte |
| isr_rd | output | 1 | Read strobe for the interrupt status byte; clears the interrupt |
| sifr_full | input | 1 | Status interface holds a word |
| sifr_data | input | 16 | Status word presented by the attachment |
| sifr_rd | output | 1 | Pops the current status word |
| ctrl_we | output | 1 | Control register write strobe |
| ctrl_data | output | 8 | Control register value |
| attn_we | output | 1 | Attention port write strobe |
| attn_data | output | 8 | Attention byte: device in 7:5, end-of-interrupt code in 4:0 |
| wake | output | 1 | Completion pulse to the waiting requester |
| result | output | 2 | 00 idle, 01 done, 10 error |
| resid | output | 16 | Latched residual block count |
| fatal | output | 1 | Sticky attention-error flag |
| stat_blk | output | 128 | Stored status block, word i at bits 16*i+15:16*i |

## Verification
Properties check the following on every cycle:
- `fatal` never falls once set.
- `result` moves only in the cycle after a dispatch.
- A status-byte read is never repeated on the next cycle.
- A control write never coincides with an attention write or a completion pulse.
- The fetch count never passes the declared length.

Only the bench scenarios can show the rest. These are the exact attention byte and the per-ID mapping to a result. They also cover word storage with zero fill, overlong blocks and paced arrivals, the residual latch for transfer commands, and the stale block kept when none is offered.

// File: rtl/stsirq_pkg.sv
// Package: shared codes for the status interrupt engine.
// Assumes a 4-bit interrupt ID field and a 5-bit command field.
package stsirq_pkg;

    localparam int ID_W  = 4;
    localparam int CMD_W = 5;

    localparam logic [ID_W-1:0] ID_OK      = 4'h1;
    localparam logic [ID_W-1:0] ID_OK_ECC  = 4'h3;
    localparam logic [ID_W-1:0] ID_OK_RTRY = 4'h5;
    localparam logic [ID_W-1:0] ID_OK_WARN = 4'h8;
    localparam logic [ID_W-1:0] ID_ABORTED = 4'h9;
    localparam logic [ID_W-1:0] ID_RST_DONE = 4'hA;
    localparam logic [ID_W-1:0] ID_XFER_RDY = 4'hB;
    localparam logic [ID_W-1:0] ID_ATTN_BAD = 4'hF;

    localparam logic [CMD_W-1:0] CMD_RD = 5'h01;
    localparam logic [CMD_W-1:0] CMD_WR = 5'h02;

    localparam logic [7:0] CTRL_GO = 8'h03;  // bit0 interrupt enable, bit1 DMA enable

    typedef enum logic [1:0] {
        RES_IDLE = 2'b00,
        RES_DONE = 2'b01,
        RES_FAIL = 2'b10
    } res_e;

    typedef enum logic [2:0] {
        CL_SPUR,   // reserved ID, ignored
        CL_XFER,   // data transfer ready
        CL_GOOD,   // successful completion
        CL_KEEP,   // reset/abort completed, no result change
        CL_ATTN,   // attention error
        CL_FAIL    // any other ID
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_DISP
    } st_e;

endpackage

// File: rtl/stsirq_decode.sv
// Module: stsirq_decode
// Classifies an interrupt ID into the dispatch class used by the engine.
// Purely combinational; assumes the ID field already masked to ID_W bits.
module stsirq_decode
    import stsirq_pkg::*;
(
    input  logic [ID_W-1:0] id,
    output cls_e            cls
);

    // Map each ID value onto its dispatch class.
    always_comb begin
        unique case (id)
            4'h0, 4'h2, 4'h4:                        cls = CL_SPUR;
            ID_XFER_RDY:                             cls = CL_XFER;
            ID_OK, ID_OK_ECC, ID_OK_RTRY, ID_OK_WARN: cls = CL_GOOD;
            ID_ABORTED, ID_RST_DONE:                 cls = CL_KEEP;
            ID_ATTN_BAD:                             cls = CL_ATTN;
            default:                                 cls = CL_FAIL;
        endcase
    end

endmodule

// File: rtl/stsirq_fetch.sv
// Module: stsirq_fetch
// Collects a self-sized status block. The first pop loads word 0, clears the
// other slots and takes the length from the word's upper byte (0 counts as 1).
// Later pops fill slots in order; words past MAX_WORDS are counted but dropped.
// Assumes pops arrive only while a block is open.
module stsirq_fetch #(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        first_pop,
    input  logic                        next_pop,
    input  logic [WORD_W-1:0]           word_in,
    output logic [MAX_WORDS*WORD_W-1:0] blk_out,
    output logic                        last_word
);

    localparam int LEN_W = WORD_W / 2;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_raw;

    assign len_raw = word_in[WORD_W-1 -: LEN_W];

    // Length and count of words taken for the open block.
    always_ff @(posedge clk) begin : p_count
        if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
        end else if (first_pop) begin
            len_q <= (len_raw == '0) ? LEN_W'(1) : len_raw;
            cnt_q <= LEN_W'(1);
        end else if (next_pop) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // The pop about to happen completes the block.
    assign last_word = ({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, len_q};

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        // One storage slot: loaded on its turn, zeroed when a new block opens.
        always_ff @(posedge clk) begin : p_slot
            if (!rst_n) begin
                slot_q <= '0;
            end else if (first_pop) begin
                slot_q <= (g == 0) ? word_in : '0;
            end else if (next_pop && cnt_q == LEN_W'(g)) begin
                slot_q <= word_in;
            end
        end
        assign blk_out[g*WORD_W +: WORD_W] = slot_q;
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_q)
        else $error("fetch count passed block length");

endmodule

// File: rtl/stsirq_engine.sv
// Module: stsirq_engine (top)
// Services one attachment interrupt at a time. It reads the status byte, fetches
// the optional status block, then dispatches on the ID for one cycle.
// Assumes irq_flag drops after isr_rd and sifr_full drops after a pop
// when no next word is waiting.
module stsirq_engine
    import stsirq_pkg::*;
#(
    parameter int          WORD_W    = 16,
    parameter int          MAX_WORDS = 8,
    parameter int          RESID_IDX = 3,
    parameter logic [4:0]  EOI_CODE  = 5'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        irq_flag,
    input  logic [7:0]                  isr_data,
    output logic                        isr_rd,
    input  logic                        sifr_full,
    input  logic [WORD_W-1:0]           sifr_data,
    output logic                        sifr_rd,
    output logic                        ctrl_we,
    output logic [7:0]                  ctrl_data,
    output logic                        attn_we,
    output logic [7:0]                  attn_data,
    output logic                        wake,
    output logic [1:0]                  result,
    output logic [WORD_W-1:0]           resid,
    output logic                        fatal,
    output logic [MAX_WORDS*WORD_W-1:0] stat_blk
);

    localparam int LEN_W = WORD_W / 2;

    st_e              state_q, state_d;
    logic [2:0]       dev_q;
    logic [ID_W-1:0]  id_q;
    logic             xfer_cmd_q;
    res_e             result_q;
    logic [WORD_W-1:0] resid_q;
    logic             fatal_q;
    cls_e             cls;
    logic             first_pop, next_pop, last_word, disp;
    logic             isr_rsvd_unused;

    assign isr_rsvd_unused = isr_data[4];

    stsirq_decode i_decode (
        .id  (id_q),
        .cls (cls)
    );

    stsirq_fetch #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS)
    ) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .first_pop (first_pop),
        .next_pop  (next_pop),
        .word_in   (sifr_data),
        .blk_out   (stat_blk),
        .last_word (last_word)
    );

    assign isr_rd    = (state_q == ST_IDLE) && irq_flag;
    assign first_pop = (state_q == ST_CHECK) && (cls != CL_SPUR) && sifr_full;
    assign next_pop  = (state_q == ST_FETCH) && sifr_full;
    assign sifr_rd   = first_pop || next_pop;
    assign disp      = (state_q == ST_DISP);

    assign ctrl_we   = disp && (cls == CL_XFER);
    assign ctrl_data = CTRL_GO;
    assign attn_we   = disp && (cls != CL_XFER) && (cls != CL_ATTN);
    assign attn_data = {dev_q, EOI_CODE};
    assign wake      = disp && (cls != CL_XFER);

    // Next-state choice for the read / fetch / dispatch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (irq_flag) state_d = ST_CHECK;
            ST_CHECK: begin
                if (cls == CL_SPUR)
                    state_d = ST_IDLE;
                else if (first_pop && sifr_data[WORD_W-1 -: LEN_W] > LEN_W'(1))
                    state_d = ST_FETCH;
                else
                    state_d = ST_DISP;
            end
            ST_FETCH: if (next_pop && last_word) state_d = ST_DISP;
            ST_DISP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture device and ID at the status byte read; note transfer commands.
    always_ff @(posedge clk) begin : p_capture
        if (!rst_n) begin
            dev_q      <= '0;
            id_q       <= '0;
            xfer_cmd_q <= 1'b0;
        end else if (isr_rd) begin
            dev_q      <= isr_data[7:5];
            id_q       <= isr_data[ID_W-1:0];
            xfer_cmd_q <= 1'b0;
        end else if (first_pop) begin
            xfer_cmd_q <= (sifr_data[CMD_W-1:0] == CMD_RD) ||
                          (sifr_data[CMD_W-1:0] == CMD_WR);
        end
    end

    // Result, residual count and fatal flag, updated in the dispatch cycle.
    always_ff @(posedge clk) begin : p_outcome
        if (!rst_n) begin
            result_q <= RES_IDLE;
            resid_q  <= '0;
            fatal_q  <= 1'b0;
        end else if (disp) begin
            if (cls == CL_GOOD)
                result_q <= RES_DONE;
            else if (cls == CL_FAIL || cls == CL_ATTN)
                result_q <= RES_FAIL;
            if (cls != CL_XFER && xfer_cmd_q)
                resid_q <= stat_blk[RESID_IDX*WORD_W +: WORD_W];
            if (cls == CL_ATTN)
                fatal_q <= 1'b1;
        end
    end

    assign result = result_q;
    assign resid  = resid_q;
    assign fatal  = fatal_q;

    p_fatal_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q |=> fatal_q)
        else $error("fatal flag cleared without reset");

    p_result_on_dispatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> $past(disp))
        else $error("result moved outside dispatch");

    p_single_isr_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rd |=> !isr_rd)
        else $error("status byte read twice in a row");

    p_ctrl_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |-> (!attn_we && !wake))
        else $error("control write with attention or wake");

    p_dispatch_returns_r12: assert property (@(posedge clk) disable iff (!rst_n)
        disp |=> (state_q == ST_IDLE))
        else $error("engine not idle after dispatch");

endmodule

// File: tb/test_stsirq_engine.sv
module test_stsirq_engine;

    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_flag = 1'b0;
    logic [7:0]   isr_data = '0;
    logic         isr_rd;
    logic         sifr_full = 1'b0;
    logic [15:0]  sifr_data = '0;
    logic         sifr_rd;
    logic         ctrl_we;
    logic [7:0]   ctrl_data;
    logic         attn_we;
    logic [7:0]   attn_data;
    logic         wake;
    logic [1:0]   result;
    logic [15:0]  resid;
    logic         fatal;
    logic [127:0] stat_blk;

    always #(CLK_PERIOD/2) clk = ~clk;

    stsirq_engine i_stsirq_engine (
        .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .isr_data(isr_data),
        .isr_rd(isr_rd), .sifr_full(sifr_full), .sifr_data(sifr_data),
        .sifr_rd(sifr_rd), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
        .attn_we(attn_we), .attn_data(attn_data), .wake(wake),
        .result(result), .resid(resid), .fatal(fatal), .stat_blk(stat_blk)
    );

    typedef struct {
        logic         ctrl;
        logic         attn;
        logic [7:0]   attn_d;
        logic         wake;
        logic [1:0]   res;
        logic [15:0]  resid;
        logic         fatal;
        logic [127:0] blk;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    int           checks = 0;
    int           errors = 0;
    int           outstanding = 0;
    int           evt_cnt = 0;
    logic [15:0]  wbuf [16];
    logic [1:0]   m_res = 2'b00;
    logic [15:0]  m_resid = '0;
    logic         m_fatal = 1'b0;
    logic [127:0] m_blk = '0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected dispatch and compares strobes, then outcome.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && (ctrl_we || attn_we || wake)) begin
                evt_cnt++;
                if (sb_q.size() == 0) begin
                    chk("R3", "unexpected dispatch strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("R6", {e.tag, " ctrl_we"}, ctrl_we, e.ctrl);
                    if (e.ctrl) chk("R6", {e.tag, " ctrl_data"}, ctrl_data, 8'h03);
                    chk("R8", {e.tag, " attn_we"}, attn_we, e.attn);
                    if (e.attn) chk("R8", {e.tag, " attn_data"}, attn_data, e.attn_d);
                    chk("R9", {e.tag, " wake"}, wake, e.wake);
                    @(negedge clk); #2;
                    chk("R7", {e.tag, " result"}, result, e.res);
                    chk("R10", {e.tag, " resid"}, resid, e.resid);
                    chk("R11", {e.tag, " fatal"}, fatal, e.fatal);
                    chk("R4", {e.tag, " stat_blk"}, stat_blk, e.blk);
                    outstanding--;
                end
            end
        end
    end

    // Driver: raises one interrupt, serves the status words, pushes expectations.
    task automatic fire(input logic [7:0] isr, input int nwords, input int gap,
                        input string tag);
        logic [3:0] id   = isr[3:0];
        bit         spur = (id == 4'h0 || id == 4'h2 || id == 4'h4);
        int         len  = 0;
        int         idx  = 0;
        int         hold = 0;
        int         pops = 0;
        int         exp_pops;
        int         evt0 = evt_cnt;
        logic [1:0] res0 = m_res;
        bit         pi, ps, cmdok;
        exp_t       e;
        if (nwords > 0) len = (wbuf[0][15:8] == 8'h00) ? 1 : int'(wbuf[0][15:8]);
        exp_pops = spur ? 0 : len;
        if (!spur) begin
            cmdok = 1'b0;
            if (nwords > 0) begin
                m_blk = '0;
                for (int i = 0; i < 8; i++)
                    if (i < len) m_blk[16*i +: 16] = wbuf[i];
                cmdok = (wbuf[0][4:0] == 5'h01) || (wbuf[0][4:0] == 5'h02);
            end
            if (id == 4'h1 || id == 4'h3 || id == 4'h5 || id == 4'h8) m_res = 2'b01;
            else if (id != 4'h9 && id != 4'hA && id != 4'hB)         m_res = 2'b10;
            if (id != 4'hB && cmdok) m_resid = m_blk[48 +: 16];
            if (id == 4'hF) m_fatal = 1'b1;
            e.ctrl   = (id == 4'hB);
            e.attn   = !(id == 4'hB || id == 4'hF);
            e.attn_d = {isr[7:5], 5'h02};
            e.wake   = (id != 4'hB);
            e.res    = m_res;
            e.resid  = m_resid;
            e.fatal  = m_fatal;
            e.blk    = m_blk;
            e.tag    = tag;
            sb_q.push_back(e);
            outstanding++;
        end
        @(negedge clk);
        isr_data  = isr;
        irq_flag  = 1'b1;
        sifr_full = (nwords > 0);
        sifr_data = wbuf[0];
        #1;
        chk("R12", {tag, " status byte read at once"}, isr_rd, 1);
        pi = isr_rd; ps = sifr_rd; if (ps) pops++;
        for (int cyc = 0; cyc < (spur ? 8 : 80); cyc++) begin
            @(negedge clk);
            if (pi) irq_flag = 1'b0;
            if (ps) begin
                idx++;
                if (idx < nwords) begin
                    if (gap > 0) begin sifr_full = 1'b0; hold = gap; end
                    else sifr_data = wbuf[idx];
                end else sifr_full = 1'b0;
            end else if (hold > 0) begin
                hold--;
                if (hold == 0) begin sifr_full = 1'b1; sifr_data = wbuf[idx]; end
            end
            #1;
            pi = isr_rd; ps = sifr_rd; if (ps) pops++;
            if (!spur && outstanding == 0 && cyc > 2) break;
        end
        sifr_full = 1'b0;
        irq_flag  = 1'b0;
        if (!spur) chk("R12", {tag, " dispatch completed"}, outstanding, 0);
        chk(spur ? "R3" : (nwords > 0 ? "R4" : "R5"), {tag, " words popped"}, pops, exp_pops);
        if (spur) begin
            chk("R3", {tag, " no dispatch strobes"}, evt_cnt, evt0);
            chk("R3", {tag, " result unchanged"}, result, res0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no strobes with the flag low
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1", "isr_rd idle", isr_rd, 0);
            chk("R1", "sifr_rd idle", sifr_rd, 0);
        end
        chk("R1", "result", result, 0);
        chk("R1", "fatal", fatal, 0);
        chk("R1", "resid", resid, 0);
        chk("R1", "stat_blk", stat_blk, 0);

        // R2 R4 R10: completion on device 1, read command, length 4
        wbuf[0] = 16'h0401; wbuf[1] = 16'h1111; wbuf[2] = 16'h2222; wbuf[3] = 16'h0005;
        fire(8'h21, 4, 0, "complete_read");
        // R6: transfer ready with no block
        fire(8'h0B, 0, 0, "xfer_ready");
        // R7 R4: failure, write command, paced words
        wbuf[0] = 16'h0602;
        for (int i = 1; i < 6; i++) wbuf[i] = 16'hA000 + 16'(i);
        fire(8'h4C, 6, 2, "failed_paced");
        // R4: zero length counts as one word; non-transfer command keeps resid
        wbuf[0] = 16'h0009;
        fire(8'h03, 1, 0, "ecc_len0");
        // R7: reset completed leaves result, still acknowledged
        fire(8'h2A, 0, 0, "reset_done");
        // R2: bit 4 set is ignored; abort on device 7
        fire(8'hF9, 0, 0, "abort_bit4");
        // R3: spurious IDs, one with a block waiting
        wbuf[0] = 16'h0201; wbuf[1] = 16'h3333;
        fire(8'h42, 2, 0, "spur_2");
        fire(8'h00, 0, 0, "spur_0");
        fire(8'h64, 0, 0, "spur_4");
        // R4 R10: overlong block, ten words, only eight stored
        wbuf[0] = 16'h0A02;
        for (int i = 1; i < 10; i++) wbuf[i] = 16'hB000 + 16'(i);
        fire(8'h25, 10, 0, "overlong");
        // R7: completed with ECC and retries counts as error
        wbuf[0] = 16'h0101;
        fire(8'h07, 1, 0, "ecc_retries");
        // R5: warning with no block keeps stored block
        fire(8'h08, 0, 0, "warn_noblk");
        // R11: attention error is sticky
        fire(8'h6F, 0, 0, "attn_error");
        fire(8'h01, 0, 0, "after_fatal");
        repeat (3) @(negedge clk);
        chk("R11", "fatal held", fatal, 1);
        chk("R9", "scoreboard drained", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule